// File: doc/BRIEF.md
# Memory Bit Manipulation Unit

This unit changes or inspects one bit of a byte held in memory. A request carries an operation code, a bit index, a 32-bit base value and a signed 16-bit displacement. The unit adds the sign-extended displacement to the base to form a byte address. It reads that byte and records whether the chosen bit was clear in its zero flag. For the three modifying operations it then writes the byte back with only that bit changed.

The memory side uses a request/ready handshake. The unit raises `mem_req` and holds the address, direction and write data steady until the memory answers with `mem_ready`. A transfer completes on the rising clock edge where both are high. When the operation is finished, the unit raises `done` for one cycle. The zero flag keeps its value between operations and changes only when a read completes.

The operation code is 2'b00 set (OR the bit in), 2'b01 invert (XOR the bit), 2'b10 clear (AND with the inverted mask) and 2'b11 test (no write). The bit index selects bit 0 (LSB) to bit 7.

Top module: `bit_rmw_unit`

## Requirements
- R1: While reset is held and after it is released, `mem_req` and `done` are low and `zero_flag` is 0.
- R2: The byte address on `mem_addr` is `base` plus `disp` sign-extended from bit 15 to 32 bits, wrapping modulo 2^32.
- R3: After the read completes, `zero_flag` is 1 if the selected bit of the byte read was 0, and 0 if it was 1. This value is the bit's state before any change.
- R4: Operation 2'b00 writes back the byte with the selected bit set to 1.
- R5: Operation 2'b01 writes back the byte with the selected bit inverted.
- R6: Operation 2'b10 writes back the byte with the selected bit cleared. The write happens even when the bit was already 0.
- R7: Operation 2'b11 performs no write (`mem_we` never high), so the byte in memory is unchanged.
- R8: A write-back leaves the seven unselected bits equal to the byte that was read.
- R9: Each accepted request produces exactly one `done` pulse, one cycle wide. A `start` raised while an operation is in progress is ignored and causes no memory access.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged in the next cycle.
- R11: `zero_flag` changes only on a completed read. It holds its value while the unit is idle and through the write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| op | input | 2 | 00 set, 01 invert, 10 clear, 11 test |
| bit_idx | input | 3 | Selected bit of the byte, 0 = LSB |
| base | input | 32 | Base address value |
| disp | input | 16 | Signed byte displacement |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with `mem_ready` on a read |
| mem_ready | input | 1 | Memory completes the current access |
| done | output | 1 | One-cycle pulse when the operation ends |
| zero_flag | output | 1 | 1 when the selected bit was 0 before the operation |

## Verification
The embedded assertions check these rules on every cycle:
- `done` is never two cycles wide.
- A test operation never issues a write.
- A write never touches bits other than the selected one.
- The request fields stay still while the memory stalls.
- The zero flag moves only when a read is accepted.

Only the bench's scenarios can show the following, because each needs a model of memory and the arithmetic outcome:
- the address arithmetic with negative displacements and wrap-around;
- the actual byte each operation produces;
- the flag value against preloaded data;
- that a second `start` during a busy operation leaves an unrelated address untouched.

// File: rtl/bit_rmw_unit.sv
module bit_rmw_unit #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [2:0]        bit_idx,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready,
  output logic              done,
  output logic              zero_flag
);

  localparam logic [1:0] OP_SET  = 2'b00;
  localparam logic [1:0] OP_INV  = 2'b01;
  localparam logic [1:0] OP_CLR  = 2'b10;
  localparam logic [1:0] OP_TEST = 2'b11;
  localparam int         EXT_W   = ADDR_W - DISP_W;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_WAIT_RD, S_WRITE, S_WAIT_WR, S_DONE
  } state_t;

  state_t            state;
  logic [1:0]        op_q;
  logic [2:0]        idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        rd_q;
  logic [7:0]        wr_q;
  logic              z_q;

  wire [7:0] mask = 8'b1 << idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_SET;
      idx_q  <= '0;
      addr_q <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      z_q    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op_q   <= op;
          idx_q  <= bit_idx;
          addr_q <= base + {{EXT_W{disp[DISP_W-1]}}, disp};
          state  <= S_READ;
        end
        S_READ:    state <= S_WAIT_RD;
        S_WAIT_RD: if (mem_ready) begin
          rd_q  <= mem_rdata;
          z_q   <= ~mem_rdata[idx_q];
          state <= (op_q == OP_TEST) ? S_DONE : S_WRITE;
        end
        S_WRITE: begin
          case (op_q)
            OP_SET:  wr_q <= rd_q | mask;
            OP_INV:  wr_q <= rd_q ^ mask;
            OP_CLR:  wr_q <= rd_q & ~mask;
            default: wr_q <= rd_q;
          endcase
          state <= S_WAIT_WR;
        end
        S_WAIT_WR: if (mem_ready) state <= S_DONE;
        S_DONE:    state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == S_WAIT_RD) || (state == S_WAIT_WR);
  assign mem_we    = (state == S_WAIT_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = wr_q;
  assign done      = (state == S_DONE);
  assign zero_flag = z_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (op_q != OP_TEST)); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R10

  AST_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (((mem_wdata ^ rd_q) & ~mask) == 8'h00)); // R8

  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && !mem_we && mem_ready) |=> $stable(zero_flag)); // R11

endmodule

// File: tb/bit_rmw_unit_test.sv
module bit_rmw_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [2:0]  bit_idx = 3'd0;
  logic [31:0] base = 32'h0;
  logic [15:0] disp = 16'h0;
  logic        mem_req, mem_we, done, zero_flag;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        mem_ready = 1'b0;

  always #5 clk = ~clk;

  bit_rmw_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_idx(bit_idx),
    .base(base), .disp(disp), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .done(done), .zero_flag(zero_flag)
  );

  typedef struct {
    logic [31:0] addr;
    logic        z;
    logic [7:0]  nb;
    logic        wr;
    string       req;
  } exp_t;

  exp_t        q[$];
  logic [7:0]  mem [logic [31:0]];
  int          checks = 0;
  int          errors = 0;
  int          lat = 0;
  int          wcnt = 0;
  int          writes_seen = 0;
  int          cyc = 0;
  logic        cap_we = 1'b0;
  logic [31:0] cap_addr = '0;
  logic [7:0]  cap_wdata = '0;
  logic        prev_done = 1'b0;
  logic        last_z = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else begin
      if (mem_ready) begin
        if (cap_we) begin
          mem[cap_addr] = cap_wdata;
          writes_seen++;
        end
        mem_ready = 1'b0;
        wcnt = 0;
      end else if (mem_req) begin
        if (wcnt >= lat) begin
          mem_ready = 1'b1;
          cap_we = mem_we;
          cap_addr = mem_addr;
          cap_wdata = mem_wdata;
          mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
          if (q.size() > 0)
            chk(mem_addr == q[0].addr, "R2", "address", mem_addr, q[0].addr);
        end else begin
          wcnt++;
        end
      end
      if (done) begin
        if (prev_done) chk(1'b0, "R9", "done wider than one cycle", 32'd1, 32'd0);
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(zero_flag == e.z, "R3", "zero flag", {31'd0, zero_flag}, {31'd0, e.z});
          chk(mem[e.addr] == e.nb, e.req, "memory byte", {24'd0, mem[e.addr]}, {24'd0, e.nb});
          chk(writes_seen == (e.wr ? 1 : 0), e.wr ? e.req : "R7", "write count",
              writes_seen, e.wr ? 32'd1 : 32'd0);
          last_z = e.z;
        end
        writes_seen = 0;
      end
      prev_done = done;
    end
  end

  task automatic push_exp(input logic [1:0] o, input logic [2:0] i, input logic [31:0] b,
                          input logic [15:0] d, input logic [7:0] init, input string req);
    exp_t e;
    logic [7:0] m;
    e.addr = b + {{16{d[15]}}, d};
    m = 8'b1 << i;
    mem[e.addr] = init;
    e.z = ~init[i];
    e.wr = (o != 2'b11);
    case (o)
      2'b00:   e.nb = init | m;
      2'b01:   e.nb = init ^ m;
      2'b10:   e.nb = init & ~m;
      default: e.nb = init;
    endcase
    e.req = req;
    q.push_back(e);
  endtask

  task automatic pulse_start(input logic [1:0] o, input logic [2:0] i,
                             input logic [31:0] b, input logic [15:0] d);
    op = o; bit_idx = i; base = b; disp = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] o, input logic [2:0] i, input logic [31:0] b,
                       input logic [15:0] d, input logic [7:0] init, input int l,
                       input string req);
    lat = l;
    push_exp(o, i, b, d, init, req);
    @(negedge clk);
    pulse_start(o, i, b, d);
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0, "R1", "req in reset", {31'd0, mem_req}, 32'd0);
    chk(done == 1'b0, "R1", "done in reset", {31'd0, done}, 32'd0);
    chk(zero_flag == 1'b0, "R1", "zero in reset", {31'd0, zero_flag}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_req == 1'b0 && done == 1'b0, "R1", "idle after reset",
        {30'd0, mem_req, done}, 32'd0);

    do_op(2'b00, 3'd3, 32'h0000_1000, 16'h0010, 8'h00, 0, "R4");
    do_op(2'b00, 3'd3, 32'h0000_1000, 16'h0010, 8'h08, 1, "R4");
    do_op(2'b01, 3'd7, 32'h0000_2000, 16'hFFF0, 8'hFF, 0, "R5");
    do_op(2'b01, 3'd0, 32'h0000_2000, 16'h0004, 8'h00, 2, "R5");
    do_op(2'b10, 3'd5, 32'h0000_3000, 16'h0001, 8'hFF, 2, "R6");
    do_op(2'b10, 3'd5, 32'h0000_3000, 16'h0002, 8'h00, 0, "R6");
    do_op(2'b01, 3'd4, 32'h0000_3000, 16'h0003, 8'hA5, 1, "R8");
    do_op(2'b11, 3'd1, 32'h0000_5000, 16'h0000, 8'h02, 1, "R7");
    do_op(2'b11, 3'd6, 32'h0000_5000, 16'h0001, 8'h00, 0, "R7");

    // R11: flag holds while idle with busy-looking inputs
    op = 2'b10; bit_idx = 3'd2; base = 32'hDEAD_0000;
    repeat (5) @(negedge clk);
    chk(zero_flag == 1'b1, "R11", "flag hold idle", {31'd0, zero_flag}, 32'd1);
    do_op(2'b00, 3'd2, 32'h0000_6000, 16'h0000, 8'h04, 2, "R11");
    repeat (4) @(negedge clk);
    chk(zero_flag == last_z, "R11", "flag hold after op", {31'd0, zero_flag}, {31'd0, last_z});

    // R2: wrap and large negative displacement
    do_op(2'b00, 3'd0, 32'hFFFF_FFF0, 16'h0020, 8'h10, 0, "R2");
    do_op(2'b10, 3'd7, 32'h0001_0000, 16'h8000, 8'h80, 1, "R2");

    // R9: second start during a busy operation is ignored
    lat = 3;
    push_exp(2'b00, 3'd2, 32'h0000_7000, 16'h0000, 8'h00, "R9");
    @(negedge clk);
    pulse_start(2'b00, 3'd2, 32'h0000_7000, 16'h0000);
    @(negedge clk);
    pulse_start(2'b10, 3'd1, 32'h0000_4000, 16'h0000);
    while (q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(!mem.exists(32'h0000_4000), "R9", "ignored start touched memory", 32'd1, 32'd0);
    chk(mem_req == 1'b0, "R9", "no extra access", {31'd0, mem_req}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule